// File: doc/BRIEF.md
# Accumulator Micro-Engine

This block is a tiny accumulator machine. It holds three state registers: an accumulator, one general register and an output register. Every clock cycle it takes a 4-bit operation code and a data word from its inputs. It then updates the registers by a fixed set of transfer rules. The operations are:

- loads from the data input;
- moves between registers;
- a wrapping add, a bitwise OR and a bitwise AND of the accumulator with the general register;
- a complement of the accumulator.

Each register has its own selection rule on the operation code. An operation therefore changes only the registers named for it, and every other register keeps its value. There is no instruction fetch, program counter, memory or flag: the operation stream and the data arrive directly from the surrounding logic, one pair per cycle, with no handshake.

The data width is a parameter, 8 bits by default. All three registers are visible on output ports.

Top module: `acc_engine`

## Requirements
- R1: Op codes 1 and 6 load the accumulator from `din`, and the new value appears after the next rising edge.
- R2: Op code 2 copies the accumulator into the general register. Op code 5 loads the general register from `din`. Every other code leaves the general register unchanged.
- R3: Op code 3 copies the general register to the output register. Op code 4 copies the accumulator to the output register. Every other code leaves the output register unchanged.
- R4: Op codes 2, 3, 4 and 5 leave the accumulator unchanged.
- R5: Op code 7 sets the accumulator to accumulator + general register, modulo 2^W with the carry discarded. Op code 8 sets it to their bitwise OR. Op code 9 sets it to their bitwise AND.
- R6: Op code 10 sets the accumulator to its bitwise complement.
- R7: Op codes 0 and 11 to 15 hold all three registers.
- R8: A synchronous reset, active high, clears all three registers to zero at the next rising edge and overrides any op code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code for this cycle |
| din | input | W | Data input word |
| acc_q | output | W | Accumulator register |
| gpr_q | output | W | General register |
| out_q | output | W | Output register |

## Verification
The in-RTL properties check on every cycle the things that depend on one code and one step:

- the hold rules for each register;
- the loads from `din`;
- the complement;
- clearing by reset.

The scenarios are the only way to show the arithmetic results:

- the add wrapping past the top of the range;
- OR and AND on chosen bit patterns;
- chains of operations, where a moved value must have been produced by an earlier operation.

A reference model checks all three registers after every edge. It does this over a directed sequence and over a long stream of random codes and data that includes a mid-run reset.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_LDA   = 4'd1,
    OP_A2G   = 4'd2,
    OP_G2O   = 4'd3,
    OP_A2O   = 4'd4,
    OP_LDG   = 4'd5,
    OP_LDA2  = 4'd6,
    OP_ADD   = 4'd7,
    OP_OR    = 4'd8,
    OP_AND   = 4'd9,
    OP_CPL   = 4'd10
  } op_e;

  typedef enum logic [2:0] {
    ASEL_HOLD, ASEL_DIN, ASEL_ADD, ASEL_OR, ASEL_AND, ASEL_NOT
  } asel_e;

  typedef enum logic [1:0] {
    GSEL_HOLD, GSEL_ACC, GSEL_DIN
  } gsel_e;

  typedef enum logic [1:0] {
    OSEL_HOLD, OSEL_GPR, OSEL_ACC
  } osel_e;

  typedef struct packed {
    asel_e asel;
    gsel_e gsel;
    osel_e osel;
  } ctl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output ctl_t            ctl
);

  always_comb begin
    ctl = '{asel: ASEL_HOLD, gsel: GSEL_HOLD, osel: OSEL_HOLD};
    case (op)
      OP_LDA, OP_LDA2: ctl.asel = ASEL_DIN;
      OP_A2G:          ctl.gsel = GSEL_ACC;
      OP_LDG:          ctl.gsel = GSEL_DIN;
      OP_G2O:          ctl.osel = OSEL_GPR;
      OP_A2O:          ctl.osel = OSEL_ACC;
      OP_ADD:          ctl.asel = ASEL_ADD;
      OP_OR:           ctl.asel = ASEL_OR;
      OP_AND:          ctl.asel = ASEL_AND;
      OP_CPL:          ctl.asel = ASEL_NOT;
      default:         ctl = '{asel: ASEL_HOLD, gsel: GSEL_HOLD, osel: OSEL_HOLD};
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  asel_e        asel,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] gpr,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc_nxt
);

  always_comb begin
    case (asel)
      ASEL_DIN: acc_nxt = din;
      ASEL_ADD: acc_nxt = acc + gpr;
      ASEL_OR:  acc_nxt = acc | gpr;
      ASEL_AND: acc_nxt = acc & gpr;
      ASEL_NOT: acc_nxt = ~acc;
      default:  acc_nxt = acc;
    endcase
  end

endmodule

// File: rtl/acc_engine.sv
module acc_engine
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    din,
  output logic [W-1:0]    acc_q,
  output logic [W-1:0]    gpr_q,
  output logic [W-1:0]    out_q
);

  ctl_t         ctl;
  logic [W-1:0] acc_nxt;
  logic [W-1:0] gpr_nxt;
  logic [W-1:0] out_nxt;

  acc_decode u_dec (
    .op  (op),
    .ctl (ctl)
  );

  acc_alu #(.W(W)) u_alu (
    .asel    (ctl.asel),
    .acc     (acc_q),
    .gpr     (gpr_q),
    .din     (din),
    .acc_nxt (acc_nxt)
  );

  always_comb begin
    case (ctl.gsel)
      GSEL_ACC: gpr_nxt = acc_q;
      GSEL_DIN: gpr_nxt = din;
      default:  gpr_nxt = gpr_q;
    endcase
  end

  always_comb begin
    case (ctl.osel)
      OSEL_GPR: out_nxt = gpr_q;
      OSEL_ACC: out_nxt = acc_q;
      default:  out_nxt = out_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      gpr_q <= '0;
      out_q <= '0;
    end else begin
      acc_q <= acc_nxt;
      gpr_q <= gpr_nxt;
      out_q <= out_nxt;
    end
  end

  // R1: accumulator loads from din
  a_r1_load_acc: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd1 || op == 4'd6) |=> acc_q == $past(din));

  // R2: general register holds unless code 2 or 5
  a_r2_gpr_hold: assert property (@(posedge clk) disable iff (rst)
    (op != 4'd2 && op != 4'd5) |=> $stable(gpr_q));

  // R3: output register holds unless code 3 or 4
  a_r3_out_hold: assert property (@(posedge clk) disable iff (rst)
    (op != 4'd3 && op != 4'd4) |=> $stable(out_q));

  // R4: move codes leave the accumulator alone
  a_r4_acc_hold: assert property (@(posedge clk) disable iff (rst)
    (op >= 4'd2 && op <= 4'd5) |=> $stable(acc_q));

  // R6: complement
  a_r6_cpl: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd10) |=> acc_q == ~$past(acc_q));

  // R7: idle codes hold every register
  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0 || op >= 4'd11) |=> ($stable(acc_q) && $stable(gpr_q) && $stable(out_q)));

  // R8: reset clears all registers
  a_r8_reset: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && gpr_q == '0 && out_q == '0));

endmodule

// File: tb/test_acc_engine.sv
`timescale 1ns/1ps
module test_acc_engine;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op  = 4'd0;
  logic [W-1:0] din = '0;
  logic [W-1:0] acc_q, gpr_q, out_q;

  logic [W-1:0] m_acc = '0, m_gpr = '0, m_out = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_engine #(.W(W)) i_acc_engine (
    .clk (clk), .rst (rst), .op (op), .din (din),
    .acc_q (acc_q), .gpr_q (gpr_q), .out_q (out_q)
  );

  function automatic string tag_of(input logic [3:0] c, input bit r);
    if (r) return "R8";
    case (c)
      4'd1, 4'd6:       return "R1";
      4'd2, 4'd5:       return "R2";
      4'd3, 4'd4:       return "R3";
      4'd7, 4'd8, 4'd9: return "R5";
      4'd10:            return "R6";
      default:          return "R7";
    endcase
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (acc_q !== m_acc || gpr_q !== m_gpr || out_q !== m_out) begin
      errors++;
      $display("FAIL %s op=%0d acc=%h gpr=%h out=%h expected acc=%h gpr=%h out=%h",
               tag, op, acc_q, gpr_q, out_q, m_acc, m_gpr, m_out);
    end
  endtask

  // drive at negedge, model the edge, check at following negedge
  task automatic step(input logic [3:0] c, input logic [W-1:0] d, input bit r);
    logic [W-1:0] na, ng, no;
    op = c; din = d; rst = r;
    na = m_acc; ng = m_gpr; no = m_out;
    if (r) begin
      na = '0; ng = '0; no = '0;
    end else begin
      if (c == 1 || c == 6) na = d;
      if (c == 7) na = W'((int'(m_acc) + int'(m_gpr)) % (1 << W));
      if (c == 8) na = m_acc | m_gpr;
      if (c == 9) na = m_acc & m_gpr;
      if (c == 10) na = ~m_acc;
      if (c == 2) ng = m_acc;
      if (c == 5) ng = d;
      if (c == 3) no = m_gpr;
      if (c == 4) no = m_acc;
    end
    @(posedge clk);
    m_acc = na; m_gpr = ng; m_out = no;
    @(negedge clk);
    compare(tag_of(c, r));
  endtask

  initial begin
    @(negedge clk);
    step(4'd1, 8'h5A, 1'b1);            // R8 reset state
    step(4'd1, 8'hFF, 1'b0);            // R1 load A
    step(4'd5, 8'h02, 1'b0);            // R2 load G
    step(4'd7, 8'h00, 1'b0);            // R5 FF+02 wraps to 01
    step(4'd4, 8'h33, 1'b0);            // R3 out = A
    step(4'd6, 8'hF0, 1'b0);            // R1 second load code
    step(4'd2, 8'h11, 1'b0);            // R2 G = A, R4 A held
    step(4'd5, 8'h3C, 1'b0);            // R2 G from din
    step(4'd8, 8'h00, 1'b0);            // R5 OR -> FC
    step(4'd9, 8'h00, 1'b0);            // R5 AND -> 3C
    step(4'd10, 8'h00, 1'b0);           // R6 complement -> C3
    step(4'd3, 8'hAA, 1'b0);            // R3 out = G, R4
    for (int k = 0; k < 6; k++)
      step(k == 0 ? 4'd0 : 4'(10 + k), 8'h77, 1'b0); // R7 idle codes
    step(4'd7, 8'h00, 1'b1);            // R8 reset overrides op
    for (int n = 0; n < 2000; n++)
      step(4'($urandom_range(0, 15)), W'($urandom), ($urandom_range(0, 199) == 0));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule